// File: doc/BRIEF.md
# Sequenced Core and Auxiliary Timer Block

The block holds one 16-bit core timer and two 16-bit auxiliary timers, all clocked from the system clock. A two-bit block prescaler code sets the length of a basic cycle. Each basic cycle is cut into sequencer slots: 8 slots, or 4 when the code is 01. The core timer is updated in the first slot. The first auxiliary timer is updated one slot gap later and the second two gaps later. Each timer also has its own 3-bit prescaler, so it advances only on some basic cycles.

When the core timer wraps past FFFFh counting up, or past 0000h counting down, it raises a one-clock interrupt pulse and flips a toggle output. It can also hand the wrap to an auxiliary timer. That timer then either reloads the core timer in its own slot or counts the wrap as the high word of a 32-bit count. Because the reload lands in a later slot, software that reads the core timer just after a wrap can see 0000h/0001h, or FFFFh/FFFEh, before the reload value appears.

Software reaches all timers and control fields through a single-cycle register write port and a combinational read port.

Top module: `tmr_block`

## Requirements
- R1: After reset all three timer values and all control fields read 0, and both irqPulse and toggleOut are 0.
- R2: Block prescaler codes 01, 00, 11 and 10 give basic cycles of 4, 8, 16 and 32 system clocks. A running core timer with individual code 0 changes exactly once per basic cycle.
- R3: An individual prescaler code k (bits [2:0] of a control register) makes its timer step once every 2^k basic cycles.
- R4: Direction bit 4 of a control register selects the count direction: 0 counts up, 1 counts down. Counting up, FFFFh wraps to 0000h. Counting down, 0000h wraps to FFFFh.
- R5: irqPulse is high for exactly one clock on each core wrap, in the same clock in which the wrapped value first reads back. toggleOut inverts at that same clock and holds otherwise.
- R6: With reload select (core control bits [6:5]) = 10, the second auxiliary value is copied into the core timer 2G clocks after the wrapped value first reads back, in every prescaler code. G is 1, 1, 2 and 4 for codes 01, 00, 11 and 10.
- R7: With reload select = 01 and code 00, 11 or 10, the first auxiliary value is copied into the core timer G clocks after the wrapped value first reads back.
- R8: With reload select = 01 and code 01, the copy from the first auxiliary timer comes one basic cycle late. With individual code 0, the core first counts once from the wrapped value (reads 0001h after an up wrap, 4 clocks after the wrap) and is then overwritten one clock later.
- R9: An auxiliary timer whose run bit (bit 3) and concatenation bit (bit 5) are set ignores its own prescaler and direction. In its slot it counts +1 after a core up-wrap and -1 after a core down-wrap.
- R10: A software write to a timer value takes priority over a hardware update in the same clock. A core write in the core slot suppresses that slot's wrap event.
- R11: Within each basic cycle the slots fire in a fixed order. The core slot comes first, the first auxiliary slot G clocks later, and the second auxiliary slot 2G clocks later. Only one slot is active in any clock.
- R12: Register addresses are 0 core value, 1 first auxiliary value, 2 second auxiliary value, 3 core control, 4 and 5 auxiliary controls. Control fields read back as written; unused bits and addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bpsCode | input | 2 | Block prescaler code, held stable between resets |
| regWrEn | input | 1 | Register write strobe, one clock per write |
| regAddr | input | 3 | Register address for read and write |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Combinational read data for regAddr |
| irqPulse | output | 1 | One-clock pulse on core wrap |
| toggleOut | output | 1 | Inverts on each core wrap |

## Verification
The assertions assume that bpsCode is changed only while reset is held, so the slot phase never jumps in the middle of a basic cycle. They also assume that regWrEn stays low during reset, so the write-priority property never looks back at a write made before the first clock. The stimulus changes the prescaler code only between resets and issues each write as a single-clock strobe from a task. Before any test that depends on the slot phase, it waits for an interrupt pulse, because that pulse fixes where the core slot falls.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PRE_W   = 3;
  localparam int CYC_W   = (1 << PRE_W) - 1;
  localparam int PER_MAX = 32;
  localparam int ADR_CORE  = 0;
  localparam int ADR_AUX0  = 1;
  localparam int ADR_CCTL  = 3;
  localparam int ADR_ACTL0 = 4;
  localparam int SEL_AUX0  = 1;
  localparam int SEL_AUX1  = 2;

  typedef struct packed {
    logic [CYC_W-1:0] cycIdx;
    logic             fast;
    logic             stepCore;
    logic             stepAux1;
    logic             stepAux2;
  } seq_strobe_t;

  typedef struct packed {
    logic [1:0]       relSel;
    logic             down;
    logic             run;
    logic [PRE_W-1:0] pre;
  } core_ctl_t;

  typedef struct packed {
    logic             cat;
    logic             down;
    logic             run;
    logic [PRE_W-1:0] pre;
  } aux_ctl_t;

  function automatic logic preTick(input logic [PRE_W-1:0] k, input logic [CYC_W-1:0] c);
    logic [CYC_W-1:0] m;
    m = CYC_W'((32'd1 << k) - 32'd1);
    return (c & m) == m;
  endfunction
endpackage

// File: rtl/tmr_aux.sv
module tmr_aux
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             step,
  input  logic [CYC_W-1:0] cycIdx,
  input  logic             wrVal,
  input  logic             wrCtl,
  input  logic [W-1:0]     wrData,
  input  logic             catUp,
  input  logic             catDn,
  output logic [W-1:0]     val,
  output aux_ctl_t         ctl
);
  localparam int CTL_W = $bits(aux_ctl_t);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      val <= '0;
      ctl <= '0;
    end else begin
      if (wrCtl) ctl <= aux_ctl_t'(wrData[CTL_W-1:0]);
      if (wrVal) begin
        val <= wrData;
      end else if (step && ctl.run) begin
        if (ctl.cat) begin
          if (catUp)      val <= val + W'(1);
          else if (catDn) val <= val - W'(1);
        end else if (preTick(ctl.pre, cycIdx)) begin
          val <= ctl.down ? val - W'(1) : val + W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/tmr_seq.sv
module tmr_seq
  import tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  bpsCode,
  output seq_strobe_t strb
);
  localparam int PH_W = $clog2(PER_MAX);

  logic [PH_W-1:0]  ph;
  logic [CYC_W-1:0] cyc;
  int               perInt, slotsInt, gapInt;
  logic [PH_W-1:0]  perLast, gap1, gap2;

  always_comb begin
    case (bpsCode)
      2'b01:   begin perInt = PER_MAX / 8; slotsInt = 4; end
      2'b00:   begin perInt = PER_MAX / 4; slotsInt = 8; end
      2'b11:   begin perInt = PER_MAX / 2; slotsInt = 8; end
      default: begin perInt = PER_MAX;     slotsInt = 8; end
    endcase
    gapInt  = perInt / slotsInt;
    perLast = PH_W'(perInt - 1);
    gap1    = PH_W'(gapInt);
    gap2    = PH_W'(2 * gapInt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ph  <= '0;
      cyc <= '0;
    end else if (ph >= perLast) begin
      ph  <= '0;
      cyc <= cyc + CYC_W'(1);
    end else begin
      ph <= ph + PH_W'(1);
    end
  end

  assign strb.cycIdx   = cyc;
  assign strb.fast     = (bpsCode == 2'b01);
  assign strb.stepCore = (ph == '0);
  assign strb.stepAux1 = (ph == gap1);
  assign strb.stepAux2 = (ph == gap2);
endmodule

// File: rtl/tmr_path.sv
module tmr_path
  import tmr_pkg::*;
#(
  parameter int W      = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strb,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [W-1:0]      regWrData,
  output logic [W-1:0]      regRdData,
  output logic              irqPulse,
  output logic              toggleOut
);
  localparam int NAUX   = 2;
  localparam int CCTL_W = $bits(core_ctl_t);
  localparam int ACTL_W = $bits(aux_ctl_t);

  core_ctl_t       coreCtl;
  logic [W-1:0]    coreVal;
  logic            reqR, armR, catUp, catDn;
  logic [W-1:0]    auxVal [NAUX];
  aux_ctl_t        auxCtl [NAUX];
  logic [NAUX-1:0] auxStep;
  logic            wrCore, wrCoreCtl, coreTick, wrapNow, evt, loadA1, loadA2;

  assign auxStep   = {strb.stepAux2, strb.stepAux1};
  assign wrCore    = regWrEn && (regAddr == ADDR_W'(ADR_CORE));
  assign wrCoreCtl = regWrEn && (regAddr == ADDR_W'(ADR_CCTL));
  assign coreTick  = strb.stepCore && coreCtl.run && preTick(coreCtl.pre, strb.cycIdx) && !wrCore;
  assign wrapNow   = coreCtl.down ? (coreVal == '0) : (coreVal == '1);
  assign evt       = coreTick && wrapNow;
  assign loadA1    = strb.stepAux1 && (coreCtl.relSel == 2'(SEL_AUX0)) && (strb.fast ? armR : reqR);
  assign loadA2    = strb.stepAux2 && (coreCtl.relSel == 2'(SEL_AUX1)) && reqR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coreVal   <= '0;
      coreCtl   <= '0;
      reqR      <= 1'b0;
      armR      <= 1'b0;
      catUp     <= 1'b0;
      catDn     <= 1'b0;
      irqPulse  <= 1'b0;
      toggleOut <= 1'b0;
    end else begin
      if (wrCoreCtl) coreCtl <= core_ctl_t'(regWrData[CCTL_W-1:0]);
      if (wrCore)        coreVal <= regWrData;
      else if (coreTick) coreVal <= coreCtl.down ? coreVal - W'(1) : coreVal + W'(1);
      else if (loadA1)   coreVal <= auxVal[0];
      else if (loadA2)   coreVal <= auxVal[1];

      if (strb.stepCore) begin
        catUp <= evt && !coreCtl.down;
        catDn <= evt && coreCtl.down;
        if (evt && (coreCtl.relSel == 2'(SEL_AUX0) || coreCtl.relSel == 2'(SEL_AUX1)))
          reqR <= 1'b1;
      end else if (strb.stepAux1 && coreCtl.relSel == 2'(SEL_AUX0)) begin
        armR <= strb.fast ? reqR : 1'b0;
        reqR <= 1'b0;
      end else if (strb.stepAux2 && coreCtl.relSel == 2'(SEL_AUX1)) begin
        reqR <= 1'b0;
      end

      irqPulse  <= evt;
      toggleOut <= toggleOut ^ evt;
    end
  end

  for (genvar g = 0; g < NAUX; g++) begin : g_aux
    tmr_aux #(.W(W)) u_aux (
      .clk    (clk),
      .rstN   (rstN),
      .step   (auxStep[g]),
      .cycIdx (strb.cycIdx),
      .wrVal  (regWrEn && (regAddr == ADDR_W'(ADR_AUX0 + g))),
      .wrCtl  (regWrEn && (regAddr == ADDR_W'(ADR_ACTL0 + g))),
      .wrData (regWrData),
      .catUp  (catUp),
      .catDn  (catDn),
      .val    (auxVal[g]),
      .ctl    (auxCtl[g])
    );
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_W'(ADR_CORE):      regRdData = coreVal;
      ADDR_W'(ADR_AUX0):      regRdData = auxVal[0];
      ADDR_W'(ADR_AUX0 + 1):  regRdData = auxVal[1];
      ADDR_W'(ADR_CCTL):      regRdData[CCTL_W-1:0] = coreCtl;
      ADDR_W'(ADR_ACTL0):     regRdData[ACTL_W-1:0] = auxCtl[0];
      ADDR_W'(ADR_ACTL0 + 1): regRdData[ACTL_W-1:0] = auxCtl[1];
      default:                regRdData = '0;
    endcase
  end
endmodule

// File: rtl/tmr_block.sv
module tmr_block
  import tmr_pkg::*;
#(
  parameter int W      = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        bpsCode,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [W-1:0]      regWrData,
  output logic [W-1:0]      regRdData,
  output logic              irqPulse,
  output logic              toggleOut
);
  seq_strobe_t seqStrb;

  tmr_seq u_seq (
    .clk     (clk),
    .rstN    (rstN),
    .bpsCode (bpsCode),
    .strb    (seqStrb)
  );

  tmr_path #(.W(W), .ADDR_W(ADDR_W)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (seqStrb),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irqPulse  (irqPulse),
    .toggleOut (toggleOut)
  );
endmodule

// File: rtl/tmr_block_chk.sv
module tmr_block_chk
  import tmr_pkg::*;
#(
  parameter int W      = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              stepCore,
  input logic              stepAux1,
  input logic              stepAux2,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [W-1:0]      regWrData,
  input logic [W-1:0]      regRdData,
  input logic              irqPulse,
  input logic              toggleOut
);
  AST_SLOT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stepCore, stepAux1, stepAux2})); // R11
  AST_CORE_SLOT_SPARSE: assert property (@(posedge clk) disable iff (!rstN)
    stepCore |=> !stepCore); // R2
  AST_IRQ_AFTER_CORE_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(stepCore)); // R11
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse); // R5
  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (toggleOut != $past(toggleOut))); // R5
  AST_TOGGLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !irqPulse |-> $stable(toggleOut)); // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regWrEn && regAddr == ADDR_W'(ADR_CORE)) && regAddr == ADDR_W'(ADR_CORE))
      |-> (regRdData == $past(regWrData))); // R10
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr > ADDR_W'(ADR_ACTL0 + 1)) |-> (regRdData == '0)); // R12
endmodule

bind tmr_block tmr_block_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .stepCore  (seqStrb.stepCore),
  .stepAux1  (seqStrb.stepAux1),
  .stepAux2  (seqStrb.stepAux2),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .irqPulse  (irqPulse),
  .toggleOut (toggleOut)
);

// File: tb/sim_tmr_block.sv
`timescale 1ns/1ps
module sim_tmr_block;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  bpsCode = 2'b00;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [15:0] regWrData = 16'd0;
  logic [15:0] regRdData;
  logic        irqPulse, toggleOut;

  int checks = 0, errors = 0;
  bit doneFlag = 0, mLive = 0;

  always #2.5 clk = ~clk;

  tmr_block u0 (.clk(clk), .rstN(rstN), .bpsCode(bpsCode), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqPulse(irqPulse), .toggleOut(toggleOut));

  // behavioural reference state
  int mPh, mB, mCore, mA[2], mIrq, mTog, mReq, mArm, mCU, mCD;
  int cK, cRun, cDown, cSel;
  int aK[2], aRun[2], aDown[2], aCat[2];

  function automatic int perOf(input logic [1:0] c);
    case (c) 2'b01: return 4; 2'b00: return 8; 2'b11: return 16; default: return 32; endcase
  endfunction
  function automatic int gapOf(input logic [1:0] c);
    case (c) 2'b01: return 1; 2'b00: return 1; 2'b11: return 2; default: return 4; endcase
  endfunction
  function automatic bit due(input int k, input int b);
    return (b % (1 << k)) == ((1 << k) - 1);
  endfunction
  function automatic int mReg(input int a);
    case (a)
      0: return mCore;
      1: return mA[0];
      2: return mA[1];
      3: return cSel*32 + cDown*16 + cRun*8 + cK;
      4: return aCat[0]*32 + aDown[0]*16 + aRun[0]*8 + aK[0];
      5: return aCat[1]*32 + aDown[1]*16 + aRun[1]*8 + aK[1];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mB = 0; mCore = 0; mA[0] = 0; mA[1] = 0; mIrq = 0; mTog = 0;
      mReq = 0; mArm = 0; mCU = 0; mCD = 0; cK = 0; cRun = 0; cDown = 0; cSel = 0;
      for (int i = 0; i < 2; i++) begin aK[i] = 0; aRun[i] = 0; aDown[i] = 0; aCat[i] = 0; end
    end else begin
      int g, nCore, nA[2], nReq, nArm, nCU, nCD, ev, wa;
      bit sc, st[2];
      g = gapOf(bpsCode);
      sc = (mPh == 0); st[0] = (mPh == g); st[1] = (mPh == 2*g);
      wa = regWrEn ? int'(regAddr) : -1;
      nCore = mCore; nA = mA; nReq = mReq; nArm = mArm; nCU = mCU; nCD = mCD; ev = 0;
      if (sc) begin
        nCU = 0; nCD = 0;
        if (cRun == 1 && due(cK, mB) && wa != 0) begin
          if (cDown == 0) begin if (mCore == 65535) nCU = 1; nCore = (mCore + 1) % 65536; end
          else begin if (mCore == 0) nCD = 1; nCore = (mCore + 65535) % 65536; end
          ev = nCU | nCD;
          if (ev == 1 && (cSel == 1 || cSel == 2)) nReq = 1;
        end
      end
      if (st[0] && cSel == 1) begin
        if (bpsCode == 2'b01) begin if (mArm == 1) nCore = mA[0]; nArm = mReq; end
        else begin if (mReq == 1) nCore = mA[0]; nArm = 0; end
        nReq = 0;
      end
      if (st[1] && cSel == 2) begin if (mReq == 1) nCore = mA[1]; nReq = 0; end
      for (int i = 0; i < 2; i++) begin
        if (st[i] && aRun[i] == 1) begin
          if (aCat[i] == 1) begin
            if (mCU == 1) nA[i] = (mA[i] + 1) % 65536;
            else if (mCD == 1) nA[i] = (mA[i] + 65535) % 65536;
          end else if (due(aK[i], mB)) begin
            nA[i] = aDown[i] == 1 ? (mA[i] + 65535) % 65536 : (mA[i] + 1) % 65536;
          end
        end
      end
      if (wa == 0) nCore = regWrData;
      if (wa == 1) nA[0] = regWrData;
      if (wa == 2) nA[1] = regWrData;
      if (wa == 3) begin cK = regWrData & 7; cRun = (regWrData >> 3) & 1; cDown = (regWrData >> 4) & 1; cSel = (regWrData >> 5) & 3; end
      for (int i = 0; i < 2; i++)
        if (wa == 4 + i) begin aK[i] = regWrData & 7; aRun[i] = (regWrData >> 3) & 1; aDown[i] = (regWrData >> 4) & 1; aCat[i] = (regWrData >> 5) & 1; end
      mCore = nCore; mA = nA; mReq = nReq; mArm = nArm; mCU = nCU; mCD = nCD;
      mIrq = ev; mTog = mTog ^ ev;
      if (mPh >= perOf(bpsCode) - 1) begin mPh = 0; mB = (mB + 1) % 128; end else mPh = mPh + 1;
    end
  end

  // every-clock comparison of the event outputs against the model (R5)
  always @(negedge clk) begin
    if (rstN && mLive && !doneFlag) begin
      checks++;
      if (int'(irqPulse) != mIrq || int'(toggleOut) != mTog) begin
        errors++;
        $display("FAIL R5 irq/toggle actual %0b/%0b expected %0d/%0d at %0t", irqPulse, toggleOut, mIrq, mTog, $time);
      end
    end
  end

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired (actual running, expected done)");
    finishRun();
  end

  task automatic doReset(input logic [1:0] code);
    @(negedge clk);
    rstN = 1'b0; bpsCode = code; regWrEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1; mLive = 1;
  endtask

  task automatic wr(input int a, input int d);
    regWrEn = 1'b1; regAddr = 3'(a); regWrData = 16'(d);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    regAddr = 3'(a);
    #1;
    v = int'(regRdData);
  endtask

  task automatic chk(input string tag, input int a, input int exp);
    int v;
    rd(a, v);
    checks++;
    if (v != exp) begin
      errors++;
      $display("FAIL %s addr %0d actual %h expected %h", tag, a, v, exp);
    end
  endtask

  task automatic mchk(input string tag);
    for (int a = 0; a < 8; a++) chk(tag, a, mReg(a));
  endtask

  task automatic bitChk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic waitIrq(input string tag);
    bit seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (irqPulse) seen = 1;
    end
    checks++;
    if (!seen) begin errors++; $display("FAIL %s irq actual 0 expected 1", tag); end
  endtask

  task automatic rateChk(input string tag, input int ctl, input int clocks, input int delta);
    int a, b;
    wr(3, ctl);
    @(negedge clk);
    rd(0, a);
    repeat (clocks) @(negedge clk);
    chk(tag, 0, (a + delta + 65536) % 65536);
    rd(0, b);
  endtask

  initial begin
    int t;
    // R1 reset state
    doReset(2'b00);
    for (int a = 0; a < 6; a++) chk("R1", a, 0);
    bitChk("R1 irq", irqPulse, 1'b0);
    bitChk("R1 toggle", toggleOut, 1'b0);

    // R12 register map and field read-back
    wr(3, 16'hFF48); chk("R12 core ctl", 3, 16'h0048);
    wr(4, 16'hFFFF); chk("R12 aux0 ctl", 4, 16'h003F);
    wr(5, 16'h0015); chk("R12 aux1 ctl", 5, 16'h0015);
    chk("R12 unmapped", 6, 0); chk("R12 unmapped", 7, 0);
    mchk("R12");

    // R2 / R4 / R3 rates and direction, code 00
    doReset(2'b00);
    rateChk("R2 code00", 16'h08, 80, 10);
    rateChk("R4 down", 16'h18, 80, -10);
    rateChk("R3 k=2", 16'h0A, 128, 4);
    rateChk("R3 k=5", 16'h0D, 1024, 4);
    doReset(2'b11); rateChk("R2 code11", 16'h08, 160, 10);
    doReset(2'b10); rateChk("R2 code10", 16'h08, 128, 4);
    doReset(2'b01); rateChk("R2 code01", 16'h08, 40, 10);

    // R5 / R6 reload from second aux, up then down, code 00
    doReset(2'b00);
    wr(2, 16'h1000); wr(0, 16'hFFFE); wr(3, 16'h48);
    waitIrq("R5");
    chk("R4 R5 wrap up", 0, 0); bitChk("R5 toggle", toggleOut, 1'b1);
    @(negedge clk); chk("R6 before", 0, 0);
    @(negedge clk); chk("R6 reload", 0, 16'h1000);
    wr(3, 16'h58); wr(0, 16'h0001);
    waitIrq("R5 down");
    chk("R4 wrap down", 0, 16'hFFFF); bitChk("R5 toggle back", toggleOut, 1'b0);
    repeat (2) @(negedge clk); chk("R6 reload down", 0, 16'h1000);
    mchk("R6");

    // R7 reload from first aux, code 00
    doReset(2'b00);
    wr(1, 16'h2000); wr(0, 16'hFFFF); wr(3, 16'h28);
    waitIrq("R7");
    chk("R7 wrap", 0, 0);
    @(negedge clk); chk("R7 reload", 0, 16'h2000);

    // R8 late reload in code 01, and second aux not late
    doReset(2'b01);
    wr(1, 16'h3000); wr(0, 16'hFFFF); wr(3, 16'h28);
    waitIrq("R8");
    chk("R8 wrap", 0, 0);
    repeat (3) @(negedge clk); chk("R8 still wrapped", 0, 0);
    @(negedge clk); chk("R8 counted once", 0, 16'h0001);
    @(negedge clk); chk("R8 late reload", 0, 16'h3000);
    repeat (4) @(negedge clk); chk("R8 after reload", 0, 16'h3001);
    doReset(2'b01);
    wr(2, 16'h3000); wr(0, 16'hFFFF); wr(3, 16'h48);
    waitIrq("R6 code01");
    repeat (2) @(negedge clk); chk("R6 code01 no delay", 0, 16'h3000);

    // R9 concatenation
    doReset(2'b00);
    wr(4, 16'h3F); wr(1, 16'h0005); wr(0, 16'hFFF0); wr(3, 16'h08);
    repeat (40) @(negedge clk); chk("R9 idle high word", 1, 16'h0005);
    waitIrq("R9 up");
    @(negedge clk); chk("R9 carry", 1, 16'h0006);
    wr(3, 16'h18); wr(0, 16'h0002);
    waitIrq("R9 down");
    @(negedge clk); chk("R9 borrow", 1, 16'h0005);
    mchk("R9");

    // R10 write in the core slot wins and suppresses the event
    doReset(2'b00);
    wr(0, 16'hFFFF); wr(3, 16'h08);
    waitIrq("R10 align");
    repeat (7) @(negedge clk);
    wr(0, 16'hFFFF);
    chk("R10 write wins", 0, 16'hFFFF);
    bitChk("R10 no irq", irqPulse, 1'b0);
    repeat (8) @(negedge clk); chk("R10 next slot", 0, 0);

    // R11 slot spacing with code 10
    doReset(2'b10);
    wr(2, 16'h0ABC); wr(0, 16'hFFFF); wr(3, 16'h48);
    waitIrq("R11");
    repeat (7) @(negedge clk); chk("R11 before aux slot", 0, 0);
    @(negedge clk); chk("R11 aux slot", 0, 16'h0ABC);
    t = 0;
    mchk("R11");
    finishRun();
  end
endmodule